// File: doc/BRIEF.md
# Byte Stack Engine Behind Special Function Registers

This block gives an 8-bit processor core a hardware byte stack that lives in external RAM. The core sees only three special function registers. Two of them hold the low and high halves of a 16-bit stack pointer. The third is a data port. Writing the data port stores the byte at the top of the stack. Reading it takes the top byte back. The pointer moves by itself in both cases.

A typical use is to save a bank-select value before a banked call and restore it afterwards. Software sets the pointer once at startup, for example to 0x8000, and then only touches the data port.

The stack grows upward. A push writes at the pointer and then increments it. A pop decrements the pointer first and then reads. Every RAM access goes through a request/grant handshake. While an access is outstanding, a stall output holds the core. Popped data is returned only after the RAM read has finished.

Top module: `xstk_sfr_stack`

## Requirements
- R1: After a synchronous reset the pointer is 0x0000, and `stall`, `mem_req` and `sfr_rvalid` are all low.
- R2: A write to SFR 0xB9 replaces pointer bits 7:0, and a write to SFR 0xBA replaces bits 15:8. A read of either address returns that byte on `sfr_rdata`, with `sfr_rvalid` high for exactly the one cycle after the read strobe.
- R3: A direct write to either pointer byte never raises `mem_req`.
- R4: A write to SFR 0xBB (push) raises `mem_req` with `mem_we` = 1 in the next cycle. The request carries `mem_addr` equal to the current pointer and the written byte on `mem_wdata`. The pointer is incremented at the clock edge where the request is granted.
- R5: A read of SFR 0xBB (pop) decrements the pointer at the strobe edge. In the next cycle it raises `mem_req` with `mem_we` = 0 and `mem_addr` equal to the decremented pointer. The RAM data from the cycle after the grant is returned with `sfr_rvalid` one cycle later.
- R6: Pops return pushed bytes in last-in, first-out order, and the pointer comes back to its value before the pushes.
- R7: The pointer wraps modulo 2^16. A push at 0x00FF carries into the high byte (giving 0x0100). A push at 0xFFFF gives 0x0000. A pop at 0x0000 reads address 0xFFFF.
- R8: `stall` is high from the cycle after a data-port strobe until the access completes, for grant delay + 1 cycles on a push and grant delay + 2 on a pop. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady while the grant is low.
- R9: A strobe to any other SFR address produces no RAM request and no `sfr_rvalid`, and leaves the pointer unchanged.
- R10: A strobe issued while `stall` is high is ignored. It causes no extra RAM access and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address of the current strobe |
| sfr_wr | input | 1 | SFR write strobe, one cycle |
| sfr_rd | input | 1 | SFR read strobe, one cycle |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, valid with sfr_rvalid |
| sfr_rvalid | output | 1 | Read data valid pulse |
| stall | output | 1 | Holds the core while a stack access is pending |
| mem_req | output | 1 | External RAM request |
| mem_we | output | 1 | External RAM write enable (1 = write) |
| mem_addr | output | 16 | External RAM byte address |
| mem_wdata | output | 8 | External RAM write data |
| mem_rdata | input | 8 | External RAM read data, one cycle after grant |
| mem_gnt | input | 1 | External RAM grant for the current request |

## Verification
A corrupt pointer shows at the RAM port on the very next data-port access, because the request address is off. It also shows on the next read of a pointer byte, one cycle after the strobe. A wrong carry or borrow only shows when the low byte crosses 0xFF or 0x00, so those crossings are driven on purpose. A stuck or early state in the sequencer shows as a stall window of the wrong length, as a request that moves while it waits for a grant, or as a second RAM write from a strobe that should have been dropped.

// File: rtl/xstk_pkg.sv
package xstk_pkg;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_PUSH,
    XS_POP_REQ,
    XS_POP_DATA
  } xs_state_e;

  typedef enum logic [2:0] {
    XC_NONE,
    XC_LO_WR,
    XC_HI_WR,
    XC_LO_RD,
    XC_HI_RD,
    XC_PUSH,
    XC_POP
  } xs_cmd_e;

endpackage

// File: rtl/xstk_decode.sv
module xstk_decode
  import xstk_pkg::*;
#(
  parameter int                SFR_AW    = 8,
  parameter logic [SFR_AW-1:0] LO_ADDR   = 8'hB9,
  parameter logic [SFR_AW-1:0] HI_ADDR   = 8'hBA,
  parameter logic [SFR_AW-1:0] PORT_ADDR = 8'hBB
) (
  input  logic [SFR_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              busy,
  output xs_cmd_e           cmd
);

  // Writes win over reads if both strobes arrive together; nothing is
  // accepted while an access is in flight.
  always_comb begin
    cmd = XC_NONE;
    if (!busy) begin
      if (wr) begin
        if (addr == LO_ADDR)        cmd = XC_LO_WR;
        else if (addr == HI_ADDR)   cmd = XC_HI_WR;
        else if (addr == PORT_ADDR) cmd = XC_PUSH;
      end else if (rd) begin
        if (addr == LO_ADDR)        cmd = XC_LO_RD;
        else if (addr == HI_ADDR)   cmd = XC_HI_RD;
        else if (addr == PORT_ADDR) cmd = XC_POP;
      end
    end
  end

endmodule

// File: rtl/xstk_ptr.sv
module xstk_ptr #(
  parameter int DATA_W  = 8,
  parameter int LANES   = 2,
  parameter int RST_VAL = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          lane_we,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      inc,
  input  logic                      dec,
  output logic [DATA_W*LANES-1:0]   ptr,
  output logic [DATA_W*LANES-1:0]   ptr_prev
);

  localparam int PTR_W = DATA_W * LANES;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] nxt;

  assign ptr_prev = ptr_q - PTR_W'(1);

  // Full-width add keeps the carry between byte lanes inside the block.
  always_comb begin
    if (inc)      stepped = ptr_q + PTR_W'(1);
    else if (dec) stepped = ptr_prev;
    else          stepped = ptr_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nxt[g*DATA_W +: DATA_W] = lane_we[g] ? wdata : stepped[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= PTR_W'(RST_VAL);
    else     ptr_q <= nxt;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/xstk_seq.sv
module xstk_seq
  import xstk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  xs_cmd_e           cmd,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  ptr_prev,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              ptr_inc,
  output logic              ptr_dec,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  xs_state_e state;

  assign busy    = (state != XS_IDLE);
  assign ptr_inc = (state == XS_PUSH) && mem_gnt;
  assign ptr_dec = (cmd == XC_POP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        XS_IDLE: begin
          case (cmd)
            XC_LO_RD: begin
              rdata  <= ptr[DATA_W-1:0];
              rvalid <= 1'b1;
            end
            XC_HI_RD: begin
              rdata  <= ptr[PTR_W-1:DATA_W];
              rvalid <= 1'b1;
            end
            XC_PUSH: begin
              state     <= XS_PUSH;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ptr;
              mem_wdata <= wdata;
            end
            XC_POP: begin
              state    <= XS_POP_REQ;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= ptr_prev;
            end
            default: ;
          endcase
        end
        XS_PUSH: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= XS_IDLE;
          end
        end
        XS_POP_REQ: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            state   <= XS_POP_DATA;
          end
        end
        XS_POP_DATA: begin
          rdata  <= mem_rdata;
          rvalid <= 1'b1;
          state  <= XS_IDLE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xstk_sfr_stack.sv
module xstk_sfr_stack
  import xstk_pkg::*;
#(
  parameter int                SFR_AW    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [SFR_AW-1:0] LO_ADDR   = 8'hB9,
  parameter logic [SFR_AW-1:0] HI_ADDR   = 8'hBA,
  parameter logic [SFR_AW-1:0] PORT_ADDR = 8'hBB,
  parameter int                PTR_RST   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SFR_AW-1:0]   sfr_addr,
  input  logic                sfr_wr,
  input  logic                sfr_rd,
  input  logic [DATA_W-1:0]   sfr_wdata,
  output logic [DATA_W-1:0]   sfr_rdata,
  output logic                sfr_rvalid,
  output logic                stall,
  output logic                mem_req,
  output logic                mem_we,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_gnt
);

  localparam int LANES = 2;
  localparam int PTR_W = DATA_W * LANES;

  xs_cmd_e          cmd;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_prev;
  logic             ptr_inc;
  logic             ptr_dec;
  logic [LANES-1:0] lane_we;

  assign lane_we = {cmd == XC_HI_WR, cmd == XC_LO_WR};

  xstk_decode #(
    .SFR_AW(SFR_AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .PORT_ADDR(PORT_ADDR)
  ) u_dec (
    .addr(sfr_addr), .wr(sfr_wr), .rd(sfr_rd), .busy(stall), .cmd(cmd)
  );

  xstk_ptr #(
    .DATA_W(DATA_W), .LANES(LANES), .RST_VAL(PTR_RST)
  ) u_ptr (
    .clk(clk), .rst(rst), .lane_we(lane_we), .wdata(sfr_wdata),
    .inc(ptr_inc), .dec(ptr_dec), .ptr(ptr), .ptr_prev(ptr_prev)
  );

  xstk_seq #(
    .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd(cmd), .ptr(ptr), .ptr_prev(ptr_prev),
    .wdata(sfr_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(stall), .ptr_inc(ptr_inc), .ptr_dec(ptr_dec),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rdata(sfr_rdata), .rvalid(sfr_rvalid)
  );

endmodule

// File: rtl/xstk_sfr_stack_chk.sv
module xstk_sfr_stack_chk #(
  parameter int                SFR_AW    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [SFR_AW-1:0] LO_ADDR   = 8'hB9,
  parameter logic [SFR_AW-1:0] HI_ADDR   = 8'hBA,
  parameter logic [SFR_AW-1:0] PORT_ADDR = 8'hBB
) (
  input logic                clk,
  input logic                rst,
  input logic [SFR_AW-1:0]   sfr_addr,
  input logic                sfr_wr,
  input logic                sfr_rd,
  input logic [DATA_W-1:0]   sfr_wdata,
  input logic                sfr_rvalid,
  input logic                stall,
  input logic                mem_req,
  input logic                mem_we,
  input logic [2*DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_gnt
);

  logic known;
  assign known = (sfr_addr == LO_ADDR) || (sfr_addr == HI_ADDR) || (sfr_addr == PORT_ADDR);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!stall && !mem_req && !sfr_rvalid));

  p_ptr_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall && sfr_wr && (sfr_addr == LO_ADDR || sfr_addr == HI_ADDR)) |=> !mem_req);

  p_push_issue_r4: assert property (@(posedge clk) disable iff (rst)
    (!stall && sfr_wr && sfr_addr == PORT_ADDR)
      |=> (mem_req && mem_we && mem_wdata == $past(sfr_wdata)));

  p_pop_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && sfr_rd && !sfr_wr && sfr_addr == PORT_ADDR) |=> (mem_req && !mem_we));

  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt)
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_req_stalls_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> stall);

  p_rvalid_free_r8: assert property (@(posedge clk) disable iff (rst)
    sfr_rvalid |-> !stall);

  p_foreign_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!stall && (sfr_wr || sfr_rd) && !known) |=> (!mem_req && !sfr_rvalid));

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (stall && mem_gnt && (sfr_wr || sfr_rd)) |=> !mem_req);

endmodule

bind xstk_sfr_stack xstk_sfr_stack_chk #(
  .SFR_AW(SFR_AW), .DATA_W(DATA_W),
  .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
  .sfr_wdata(sfr_wdata), .sfr_rvalid(sfr_rvalid), .stall(stall),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
);

// File: tb/sim_xstk_sfr_stack.sv
module sim_xstk_sfr_stack;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_wr = 1'b0;
  logic        sfr_rd = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        sfr_rvalid;
  logic        stall;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_gnt = 1'b0;

  always #2 clk = ~clk;

  xstk_sfr_stack u0 (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_rvalid(sfr_rvalid),
    .stall(stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  // Synchronous RAM model: 256 bytes indexed by the low address byte.
  logic [7:0] ram [0:255];
  logic [7:0] ram_q = '0;
  assign mem_rdata = ram_q;
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      ram_q <= ram[mem_addr[7:0]];
    end
  end

  // Grant after gnt_delay waiting cycles.
  int gnt_delay = 0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= gnt_delay) mem_gnt <= 1'b1;
      else begin mem_gnt <= 1'b0; wcnt <= wcnt + 1; end
    end else begin
      mem_gnt <= 1'b0;
      wcnt <= 0;
    end
  end

  // Port monitors, sampled at the rising edge.
  bit          got_rv, got_req;
  logic [7:0]  rv_data, req_wdata;
  logic [15:0] req_addr, gnt_addr;
  logic        req_we;
  int          req_cnt, wr_cnt, stall_cnt;
  always @(posedge clk) begin
    if (sfr_rvalid) begin got_rv = 1; rv_data = sfr_rdata; end
    if (mem_req && !got_req) begin
      got_req = 1; req_addr = mem_addr; req_we = mem_we; req_wdata = mem_wdata;
    end
    if (mem_req) req_cnt++;
    if (mem_req && mem_gnt) gnt_addr = mem_addr;
    if (mem_req && mem_gnt && mem_we) wr_cnt++;
    if (stall) stall_cnt++;
  end

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [15:0] mptr = 16'h0000;

  // op: 0 write, 1 read with expected data, 2 read expecting no response
  task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] d,
                       input string tag);
    logic [15:0] eaddr;
    bit port;
    int cyc;
    eaddr = '0;
    port  = (a == 8'hBB);
    if (port) begin
      if (op == 0) begin eaddr = mptr; mptr = mptr + 16'd1; end
      else begin mptr = mptr - 16'd1; eaddr = mptr; end
    end else if (op == 0 && a == 8'hB9) mptr[7:0] = d;
    else if (op == 0 && a == 8'hBA) mptr[15:8] = d;
    got_rv = 0; got_req = 0;
    sfr_addr = a; sfr_wdata = d; sfr_wr = (op == 0); sfr_rd = (op != 0);
    @(negedge clk);
    sfr_wr = 0; sfr_rd = 0;
    if (port) chk("R8", "stall after data-port strobe", 32'(stall), 32'd1);
    cyc = 0;
    while (stall && cyc < 50) begin @(negedge clk); cyc++; end
    repeat (3) @(negedge clk);
    if (port) begin
      chk(op == 0 ? "R4" : "R5", "request seen", 32'(got_req), 32'd1);
      chk(op == 0 ? "R4" : "R5", "request address", 32'(req_addr), 32'(eaddr));
      chk(op == 0 ? "R4" : "R5", "request direction", 32'(req_we), 32'(op == 0));
      if (op == 0) chk("R4", "push data", 32'(req_wdata), 32'(d));
    end
    if (op == 1) begin
      chk(tag, "read valid", 32'(got_rv), 32'd1);
      chk(tag, "read data", 32'(rv_data), 32'(d));
    end
    if (op == 2) chk(tag, "no read response", 32'(got_rv), 32'd0);
  endtask

  localparam int NV = 33;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {2'd0, 8'hBA, 8'h80}, {2'd0, 8'hB9, 8'h00}, {2'd1, 8'hBA, 8'h80}, {2'd1, 8'hB9, 8'h00},
    {2'd0, 8'hBB, 8'h11}, {2'd0, 8'hBB, 8'h22}, {2'd0, 8'hBB, 8'h33}, {2'd1, 8'hB9, 8'h03},
    {2'd1, 8'hBB, 8'h33}, {2'd1, 8'hBB, 8'h22}, {2'd1, 8'hB9, 8'h01}, {2'd1, 8'hBB, 8'h11},
    {2'd1, 8'hBA, 8'h80},
    {2'd0, 8'hB9, 8'hFF}, {2'd0, 8'hBA, 8'h00}, {2'd0, 8'hBB, 8'h5A}, {2'd1, 8'hBA, 8'h01},
    {2'd1, 8'hB9, 8'h00}, {2'd1, 8'hBB, 8'h5A}, {2'd1, 8'hBA, 8'h00}, {2'd1, 8'hB9, 8'hFF},
    {2'd0, 8'hBA, 8'hFF}, {2'd0, 8'hB9, 8'hFF}, {2'd0, 8'hBB, 8'hC3}, {2'd1, 8'hBA, 8'h00},
    {2'd1, 8'hB9, 8'h00}, {2'd1, 8'hBB, 8'hC3}, {2'd1, 8'hBA, 8'hFF}, {2'd1, 8'hB9, 8'hFF},
    {2'd0, 8'h80, 8'h77}, {2'd2, 8'h80, 8'h00}, {2'd1, 8'hB9, 8'hFF}, {2'd1, 8'hBA, 8'hFF}
  };

  function automatic string vec_tag(input int i);
    if (i < 4)   return "R2";
    if (i < 13)  return "R6";
    if (i < 29)  return "R7";
    return "R9";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle outputs and zero pointer after reset
    chk("R1", "stall", 32'(stall), 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    chk("R1", "rvalid", 32'(sfr_rvalid), 32'd0);
    do_op(1, 8'hB9, 8'h00, "R1");
    do_op(1, 8'hBA, 8'h00, "R1");

    // R3: pointer writes stay off the RAM port
    req_cnt = 0;
    do_op(0, 8'hB9, 8'h44, "R3");
    do_op(0, 8'hBA, 8'h12, "R3");
    chk("R3", "requests from pointer writes", 32'(req_cnt), 32'd0);
    do_op(1, 8'hB9, 8'h44, "R2");

    for (int i = 0; i < NV; i++)
      do_op(int'(VEC[i][17:16]), VEC[i][15:8], VEC[i][7:0], vec_tag(i));

    // R8 / R10: slow grant, strobe during stall
    gnt_delay = 3;
    do_op(0, 8'hBA, 8'h20, "R2");
    do_op(0, 8'hB9, 8'h00, "R2");
    stall_cnt = 0; wr_cnt = 0; got_req = 0;
    sfr_addr = 8'hBB; sfr_wdata = 8'h66; sfr_wr = 1;
    @(negedge clk);
    sfr_wr = 0;
    @(negedge clk);
    sfr_wdata = 8'h99; sfr_wr = 1;
    @(negedge clk);
    sfr_wr = 0;
    while (stall) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8", "push stall cycles", 32'(stall_cnt), 32'(gnt_delay + 1));
    chk("R8", "address held until grant", 32'(gnt_addr), 32'(req_addr));
    chk("R10", "writes during stall", 32'(wr_cnt), 32'd1);
    mptr = 16'h2001;
    do_op(1, 8'hB9, 8'h01, "R10");
    stall_cnt = 0;
    do_op(1, 8'hBB, 8'h66, "R8");
    chk("R8", "pop stall cycles", 32'(stall_cnt), 32'(gnt_delay + 2));
    do_op(1, 8'hB9, 8'h00, "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule